// File: doc/BRIEF.md
# Interval Timer with Sticky Alarm Flag

This block keeps elapsed time for a battery-backed slave device. A 40-bit binary counter advances by one on every cycle in which the 256 Hz tick enable is high and counting is allowed. The lowest counter byte therefore holds 1/256-second fractions, and the upper four bytes hold whole seconds. A control bit starts and stops counting. This bit is inverted: writing 0 lets the counter run and writing 1 halts it.

A 40-bit alarm register sits beside the counter. When a tick moves the counter onto the alarm value, a sticky interval-alarm flag is set in the status register. Software reads that register through a byte-wide register port, and the read itself clears the flag. An alarm event that lands in the same cycle as a status read is kept, so no event is lost. Read data is combinational from the address, so peeking at an address without the read strobe has no side effect.

Top module: `ivl_timer`

## Requirements
- R1: With the halt bit at 0 and no counter-byte write in the cycle, each cycle with `tick256` high adds one to the 40-bit counter. Cycles without a tick leave the counter unchanged.
- R2: Counter byte k is at address k (k = 0..4) and holds counter bits 8k+7:8k. Byte 0 is the fractional-second byte. `rdData` shows the addressed byte in the same cycle.
- R3: The control register is at address 10, and its bit 0 is the halt bit. 1 stops counting and 0 lets it run. A write takes effect from the next cycle. Reading address 10 returns {7'b0, halt}.
- R4: A write to a counter byte (addresses 0..4) replaces that byte from the next cycle and leaves the other bytes unchanged. Any tick in that same cycle is discarded.
- R5: Alarm byte k is at address 5+k and holds alarm bits 8k+7:8k. The compare covers all 40 bits. The flag becomes visible in the cycle after a tick whose increment makes the counter equal the alarm value. Equality reached by a write, or held while halted, does not set the flag.
- R6: The status register is at address 11, with the interval-alarm flag in bit 4. Bits 3 and 5 are alarm slots for other timekeeping sources that this block does not have, and they read 0, as do all other bits. A read (`rdEn` high with address 11) returns the current value and clears the flag from the next cycle.
- R7: The flag stays set until it is read. An alarm event in the same cycle as a status read leaves the flag set afterwards.
- R8: The counter wraps from all-ones to zero without setting the flag, unless the alarm value is zero.
- R9: After reset, the counter and alarm are zero, the halt bit is 1 and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| tick256 | input | 1 | One-cycle 256 Hz count enable |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe for the addressed register |
| rdEn | input | 1 | Read strobe; a read of address 11 clears the flag |
| rdData | output | 8 | Read data of the addressed register, combinational |

## Verification
The assertions assume that `addr`, `wrEn`, `rdEn` and `tick256` are stable around each rising edge. They also assume that a counter write and a tick in the same cycle is a legal case in which the write wins. The assertions do not depend on the tick spacing, so the stimulus uses dense ticks, ticks every other cycle and random ticks. The stimulus also moves the counter next to the alarm value and next to the all-ones wrap point by writing it directly. This reaches the match, wrap and read-collision cases in a few cycles rather than after 2^40 ticks.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
  localparam int CNT_BYTES = 5;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = CNT_BYTES * BYTE_W;
  localparam int ADDR_W    = 4;
  localparam int ALM_BASE  = CNT_BYTES;
  localparam int CTL_ADDR  = 2 * CNT_BYTES;
  localparam int STAT_ADDR = CTL_ADDR + 1;
  localparam int FLAG_BIT  = 4;

  typedef struct packed {
    logic [CNT_BYTES-1:0] cntWr;
    logic [CNT_BYTES-1:0] almWr;
    logic                 ctlWr;
    logic                 statRd;
  } ivl_strobes_t;
endpackage

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
  import ivl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [CNT_W-1:0]      count,
  input  logic [CNT_W-1:0]      alarm,
  input  logic                  halt,
  input  logic                  flag,
  output ivl_strobes_t          strobes,
  output logic [BYTE_W-1:0]     rdData
);
  genvar gi;
  generate
    for (gi = 0; gi < CNT_BYTES; gi++) begin : g_dec
      assign strobes.cntWr[gi] = wrEn && (addr == ADDR_W'(gi));
      assign strobes.almWr[gi] = wrEn && (addr == ADDR_W'(ALM_BASE + gi));
    end
  endgenerate

  assign strobes.ctlWr  = wrEn && (addr == ADDR_W'(CTL_ADDR));
  assign strobes.statRd = rdEn && (addr == ADDR_W'(STAT_ADDR));

  logic [BYTE_W-1:0] statusByte;
  always_comb begin
    statusByte = '0;
    statusByte[FLAG_BIT] = flag;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < CNT_BYTES; k++) begin
      if (addr == ADDR_W'(k))            rdData = count[k*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(ALM_BASE + k)) rdData = alarm[k*BYTE_W +: BYTE_W];
    end
    if (addr == ADDR_W'(CTL_ADDR))  rdData = {{(BYTE_W-1){1'b0}}, halt};
    if (addr == ADDR_W'(STAT_ADDR)) rdData = statusByte;
  end

  // R6: unused alarm slots (bits 3 and 5) never read as 1
  a_r6_spare_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(STAT_ADDR)) |-> (rdData[3] == 1'b0 && rdData[5] == 1'b0));

  // R4, R5: at most one register is written per cycle
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cntWr, strobes.almWr, strobes.ctlWr}));
endmodule

// File: rtl/ivl_datapath.sv
module ivl_datapath
  import ivl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick256,
  input  logic [BYTE_W-1:0]  wrData,
  input  ivl_strobes_t       strobes,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   alarm,
  output logic               halt,
  output logic               flag
);
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] incVal;
  logic             anyCntWr;
  logic             incEn;
  logic             matchEvt;

  assign anyCntWr = |strobes.cntWr;
  assign incEn    = tick256 && !halt && !anyCntWr;
  assign incVal   = count + CNT_W'(1);
  assign matchEvt = incEn && (incVal == alarm);

  always_comb begin
    cntNext = count;
    if (anyCntWr) begin
      for (int k = 0; k < CNT_BYTES; k++)
        if (strobes.cntWr[k]) cntNext[k*BYTE_W +: BYTE_W] = wrData;
    end else if (incEn) begin
      cntNext = incVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= cntNext;
  end

  genvar gi;
  generate
    for (gi = 0; gi < CNT_BYTES; gi++) begin : g_alm
      always_ff @(posedge clk) begin
        if (!rstN)                  alarm[gi*BYTE_W +: BYTE_W] <= '0;
        else if (strobes.almWr[gi]) alarm[gi*BYTE_W +: BYTE_W] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              halt <= 1'b1;
    else if (strobes.ctlWr) halt <= wrData[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) flag <= 1'b0;
    else       flag <= (flag && !strobes.statRd) || matchEvt;
  end

  // R1: a permitted tick advances the count by exactly one
  a_r1_inc: assert property (@(posedge clk) disable iff (!rstN)
    (tick256 && !halt && !anyCntWr) |=> (count == $past(count) + CNT_W'(1)));

  // R3: a halted counter with no write holds its value
  a_r3_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (halt && !anyCntWr) |=> $stable(count));

  // R5: a tick onto the alarm value leaves the flag set
  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |=> flag);

  // R6: a status read with no new event clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.statRd && !matchEvt) |=> !flag);

  // R7: the flag is sticky until read
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strobes.statRd) |=> flag);

  // R8: without an alarm match the flag never rises
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!flag && !matchEvt) |=> !flag);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick256,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [BYTE_W-1:0] rdData
);
  ivl_strobes_t     strobes;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] alarm;
  logic             halt;
  logic             flag;

  ivl_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .count   (count),
    .alarm   (alarm),
    .halt    (halt),
    .flag    (flag),
    .strobes (strobes),
    .rdData  (rdData)
  );

  ivl_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick256 (tick256),
    .wrData  (wrData),
    .strobes (strobes),
    .count   (count),
    .alarm   (alarm),
    .halt    (halt),
    .flag    (flag)
  );
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick256 = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int  nTests = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rstN(rstN), .tick256(tick256), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
  );

  // behavioural reference model
  logic [39:0] mCount, mAlarm;
  logic        mHalt, mFlag;

  always @(posedge clk) begin
    logic [39:0] nc;
    logic        hit;
    logic        cw;
    if (!rstN) begin
      mCount = 40'd0; mAlarm = 40'd0; mHalt = 1'b1; mFlag = 1'b0;
    end else begin
      hit = 1'b0;
      nc  = mCount;
      cw  = wrEn && (addr < 4'd5);
      if (!cw && tick256 && !mHalt) begin
        nc  = mCount + 40'd1;
        hit = (nc == mAlarm);
      end
      mFlag = (mFlag && !(rdEn && addr == 4'd11)) || hit;
      if (cw) nc[addr*8 +: 8] = wrData;
      mCount = nc;
      if (wrEn && addr >= 4'd5 && addr <= 4'd9) mAlarm[(addr-4'd5)*8 +: 8] = wrData;
      if (wrEn && addr == 4'd10) mHalt = wrData[0];
    end
  end

  function automatic logic [7:0] mRead(input logic [3:0] a);
    if (a < 4'd5)                return mCount[a*8 +: 8];
    else if (a <= 4'd9)          return mAlarm[(a-4'd5)*8 +: 8];
    else if (a == 4'd10)         return {7'd0, mHalt};
    else if (a == 4'd11)         return {3'd0, mFlag, 4'd0};
    else                         return 8'd0;
  endfunction

  function automatic string tagOf(input logic [3:0] a);
    if (a < 4'd5)       return "R2";
    else if (a <= 4'd9) return "R5";
    else if (a == 4'd10) return "R3";
    else                return "R6";
  endfunction

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rstN && !done) begin
      nTests++;
      if (rdData !== mRead(addr)) begin
        nFail++;
        $display("FAIL %s model compare addr=%0d actual=%02h expected=%02h",
                 tagOf(addr), addr, rdData, mRead(addr));
      end
    end
  end

  task automatic cyc(input logic [3:0] a, input logic [7:0] d,
                     input logic w, input logic r, input logic t);
    @(negedge clk);
    addr = a; wrData = d; wrEn = w; rdEn = r; tick256 = t;
  endtask

  task automatic peek(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cyc(a, 8'd0, 1'b0, 1'b0, 1'b0);
    #2;
    nTests++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdData, exp);
    end
  endtask

  task automatic run(input int n, input int period);
    for (int i = 0; i < n; i++) cyc(4'd0, 8'd0, 1'b0, 1'b0, (i % period) == 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    for (int k = 0; k < 10; k++) peek(4'(k), 8'h00, "R9");
    peek(4'd10, 8'h01, "R9");
    peek(4'd11, 8'h00, "R9");
    // R3: halted after reset ignores ticks
    run(6, 1);
    peek(4'd0, 8'h00, "R3");
    // R1: start and count dense ticks
    cyc(4'd10, 8'h00, 1'b1, 1'b0, 1'b0);
    run(20, 1);
    peek(4'd0, 8'h14, "R1");
    // R2: carry into the seconds byte, ticks every other cycle
    run(600, 2);
    peek(4'd0, 8'h40, "R2");
    peek(4'd1, 8'h01, "R2");
    peek(4'd2, 8'h00, "R2");
    // R3: stop and check hold
    cyc(4'd10, 8'h01, 1'b1, 1'b0, 1'b0);
    run(10, 1);
    peek(4'd0, 8'h40, "R3");
    peek(4'd10, 8'h01, "R3");
    // R4: writes while running with a tick in every write cycle
    cyc(4'd10, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) cyc(4'(k), 8'hFF, 1'b1, 1'b0, 1'b1);
    cyc(4'd10, 8'h01, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) peek(4'(k), 8'hFF, "R4");
    // alarm = 3
    cyc(4'd5, 8'h03, 1'b1, 1'b0, 1'b0);
    for (int k = 6; k < 10; k++) cyc(4'(k), 8'h00, 1'b1, 1'b0, 1'b0);
    peek(4'd5, 8'h03, "R5");
    // R8: wrap to zero then 1, 2: no flag
    cyc(4'd10, 8'h00, 1'b1, 1'b0, 1'b0);
    run(3, 1);
    peek(4'd11, 8'h00, "R8");
    peek(4'd0, 8'h02, "R8");
    peek(4'd4, 8'h00, "R8");
    // R5: next tick hits the alarm
    run(1, 1);
    peek(4'd11, 8'h10, "R5");
    // R7: stays set through further ticks
    run(5, 1);
    peek(4'd11, 8'h10, "R7");
    // R6: read returns value then clears
    cyc(4'd11, 8'h00, 1'b0, 1'b1, 1'b0);
    #2;
    nTests++;
    if (rdData !== 8'h10) begin
      nFail++;
      $display("FAIL R6 read value actual=%02h expected=10", rdData);
    end
    peek(4'd11, 8'h00, "R6");
    // R7: match in the same cycle as a status read
    cyc(4'd10, 8'h01, 1'b1, 1'b0, 1'b0);
    cyc(4'd0, 8'h02, 1'b1, 1'b0, 1'b0);
    for (int k = 1; k < 5; k++) cyc(4'(k), 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(4'd10, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(4'd11, 8'h00, 1'b0, 1'b1, 1'b1);
    peek(4'd11, 8'h10, "R7");
    cyc(4'd11, 8'h00, 1'b0, 1'b1, 1'b0);
    peek(4'd11, 8'h00, "R6");
    // R5: equality by write while halted does not set the flag
    cyc(4'd10, 8'h01, 1'b1, 1'b0, 1'b0);
    cyc(4'd0, 8'h03, 1'b1, 1'b0, 1'b1);
    run(4, 1);
    peek(4'd11, 8'h00, "R5");
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 11));
      cyc(a, 8'($urandom), ($urandom_range(0, 15) == 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) != 0));
    end
    run(5, 1);
    summary();
  end
endmodule